// File: doc/BRIEF.md
# Bidirectional GPIO port with pull-ups

This block is an eight-pin general-purpose I/O port. It holds two control registers and has one input view. The direction register sets each pin as an input or an output. The output-value register sets the level a driving pin puts out. On a pin that is an input, the same bit turns on that pin's pull-up. The input view returns the level each pin actually has. The host reaches these through a two-bit address with a write strobe. Read data is combinational from the selected source.

Each pin drives three pad controls: output value, output enable and pull-up enable. These feed a per-pin tri-state pad model that resolves the pin's logic level from four sources. In priority order they are the port's own driver, an external driver and the pull-up; with none of these the pin reads low. The resolved levels cross a two-flop synchroniser before the host can read them.

Writing to the input-view address does not load anything. Instead it flips every output-value bit whose written bit is 1, which gives software a single-write toggle for selected pins.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output-value registers are 0. Every pin is an input with pad_oe, pad_out and pad_pullup all 0, and the input view reads 0.
- R2: The address map is 0 = input view, 1 = direction, 2 = output value, 3 = unused. A write to address 1 or 2 stores bus_wdata at the rising edge. A read returns the selected register in the same cycle.
- R3: A direction bit of 1 sets pad_oe for that pin, and pad_out then equals the output-value bit. A direction bit of 0 clears pad_oe and forces pad_out to 0.
- R4: pad_pullup is 1 exactly when the pin's direction bit is 0 and its output-value bit is 1. Making the pin an output, or clearing its output-value bit, turns the pull-up off.
- R5: The pad model resolves each pin in priority order. A pin with pad_oe set takes pad_out, even against an external driver. Otherwise it takes ext_drive_val when ext_drive_en is set, then 1 when the pull-up is on, and 0 when none of these apply.
- R6: Reading address 0 returns the resolved pin levels for all pins, whatever their direction. A level change becomes visible after the second rising edge that follows it, and not after the first.
- R7: A write to address 0 inverts each output-value bit whose bus_wdata bit is 1. Bits written as 0 keep their value, and the direction register is unchanged, whatever the direction bits are.
- R8: A write to address 3 changes no register and no pad control, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_drive_en | input | 8 | Per-pin external driver enable |
| ext_drive_val | input | 8 | Per-pin external driver level |
| pad_out | output | 8 | Output value to pad |
| pad_oe | output | 8 | Output enable to pad |
| pad_pullup | output | 8 | Pull-up enable to pad |
| pin_level | output | 8 | Resolved pin levels from pad model |

## Verification
The bench builds the port at its default width of eight pins. That width is enough for walking patterns to mix input and output pins within one byte. In the same write, the toggle address can flip pins that are driving and pins that are pulled up. The external driver inputs let the bench cover contention, a floating pin with its pull-up, and a floating pin without one. It checks the two-edge synchroniser latency on the exact cycles on either side of the change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PINS = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_VAL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] val_q
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] val;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            case (reg_sel_e'(addr))
                SEL_DIR:  ctrl_d.dir = wdata;
                SEL_VAL:  ctrl_d.val = wdata;
                SEL_PINS: ctrl_d.val = ctrl_q.val ^ wdata;
                default:  ctrl_d = ctrl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign dir_q = ctrl_q.dir;
    assign val_q = ctrl_q.val;

    // R7: toggle write flips selected bits only, direction untouched
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == SEL_PINS) |=> (val_q == ($past(val_q) ^ $past(wdata))) && $stable(dir_q));

    // R8: idle cycles and unused address leave both registers unchanged
    assert_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || addr == SEL_NONE) |=> $stable(dir_q) && $stable(val_q));

    // R2: direction write stores the data
    assert_dir_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == SEL_DIR) |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] async_in,
    output logic [NUM_PINS-1:0] sync_out
);
    typedef struct packed {
        logic [NUM_PINS-1:0] stage1;
        logic [NUM_PINS-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.stage1 = async_in;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stage2;

    // R6: second stage follows the first one cycle later
    assert_stage_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_q.stage2 == $past(sync_q.stage1));
endmodule

// File: rtl/gpio_pad_model.sv
module gpio_pad_model #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] drv_val,
    input  logic [NUM_PINS-1:0] drv_en,
    input  logic [NUM_PINS-1:0] pull_en,
    input  logic [NUM_PINS-1:0] ext_en,
    input  logic [NUM_PINS-1:0] ext_val,
    output logic [NUM_PINS-1:0] level
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        always_comb begin
            if (drv_en[p])       level[p] = drv_val[p];
            else if (ext_en[p])  level[p] = ext_val[p];
            else if (pull_en[p]) level[p] = 1'b1;
            else                 level[p] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] ext_drive_en,
    input  logic [NUM_PINS-1:0] ext_drive_val,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pullup,
    output logic [NUM_PINS-1:0] pin_level
);
    logic [NUM_PINS-1:0] dir_q, val_q, pins_sync;

    gpio_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .dir_q(dir_q), .val_q(val_q)
    );

    assign pad_oe     = dir_q;
    assign pad_out    = val_q & dir_q;
    assign pad_pullup = val_q & ~dir_q;

    gpio_pad_model #(.NUM_PINS(NUM_PINS)) i_pad (
        .drv_val(pad_out), .drv_en(pad_oe), .pull_en(pad_pullup),
        .ext_en(ext_drive_en), .ext_val(ext_drive_val), .level(pin_level)
    );

    gpio_sync #(.NUM_PINS(NUM_PINS)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_level), .sync_out(pins_sync)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_PINS: bus_rdata = pins_sync;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_VAL:  bus_rdata = val_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R3: a driving pin resolves to its driven value
    assert_drive_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & pad_oe) == (pad_out & pad_oe));

    // R4: the pull-up is never on for a driving pin
    assert_pull_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pullup & pad_oe) == '0);

    // R5: a pulled-up pin with no external driver reads high
    assert_pull_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pullup & ~ext_drive_en & ~pin_level) == '0);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] ext_drive_en = 8'h00;
    logic [7:0] ext_drive_val = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pullup, pin_level;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_drive_en(ext_drive_en), .ext_drive_val(ext_drive_val),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
        .pin_level(pin_level)
    );

    // {addr, wdata, expected oe, expected out, expected pullup}
    localparam logic [33:0] VEC [0:7] = '{
        {2'd1, 8'h0F, 8'h0F, 8'h00, 8'h00},
        {2'd2, 8'h3C, 8'h0F, 8'h0C, 8'h30},
        {2'd0, 8'h81, 8'h0F, 8'h0D, 8'hB0},
        {2'd1, 8'hF0, 8'hF0, 8'hB0, 8'h0D},
        {2'd3, 8'hFF, 8'hF0, 8'hB0, 8'h0D},
        {2'd0, 8'hFF, 8'hF0, 8'h40, 8'h02},
        {2'd0, 8'h00, 8'hF0, 8'h40, 8'h02},
        {2'd2, 8'h00, 8'hF0, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pads", {8'h0, pad_oe, pad_out, pad_pullup}, 32'h0);
        bus_read(2'd0, rd); check("R1 pins", {24'h0, rd}, 32'h0);
        bus_read(2'd1, rd); check("R1 dir", {24'h0, rd}, 32'h0);
        bus_read(2'd2, rd); check("R1 val", {24'h0, rd}, 32'h0);

        // R2 R3 R4 R7 R8: table walk
        for (int v = 0; v < 8; v++) begin
            bus_write(VEC[v][33:32], VEC[v][31:24]);
            check("R3/R4/R7/R8 table", {8'h0, pad_oe, pad_out, pad_pullup},
                  {8'h0, VEC[v][23:0]});
        end

        // R2: readback of stored registers
        bus_read(2'd1, rd); check("R2 dir readback", {24'h0, rd}, 32'hF0);
        bus_read(2'd2, rd); check("R2 val readback", {24'h0, rd}, 32'h00);
        // R8: unused address reads 0 after being written
        bus_read(2'd3, rd); check("R8 unused read", {24'h0, rd}, 32'h00);

        // R6: latency of two edges, inputs from external driver
        bus_write(2'd1, 8'h00);
        wait_cycles(3);
        bus_addr = 2'd0;
        ext_drive_en  = 8'hFF;
        ext_drive_val = 8'hA5;
        @(posedge clk); @(negedge clk);
        bus_read(2'd0, rd); check("R6 after one edge", {24'h0, rd}, 32'h00);
        @(posedge clk); @(negedge clk);
        bus_read(2'd0, rd); check("R6 after two edges", {24'h0, rd}, 32'hA5);

        // R5: floating pins with and without pull-up
        ext_drive_en = 8'h00;
        bus_write(2'd2, 8'h0F);
        check("R4 pullup on inputs", {24'h0, pad_pullup}, 32'h0F);
        wait_cycles(3);
        bus_read(2'd0, rd); check("R5 pulled high", {24'h0, rd}, 32'h0F);

        // R4: making a pin an output removes its pull-up
        bus_write(2'd1, 8'h01);
        check("R4 pullup off for output", {24'h0, pad_pullup}, 32'h0E);

        // R5 R6: driving pins win over external driver; read independent of DIR
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'h3C);
        ext_drive_en  = 8'hFF;
        ext_drive_val = 8'hC3;
        wait_cycles(3);
        check("R5 contention level", {24'h0, pin_level}, 32'h3C);
        bus_read(2'd0, rd); check("R6 read output pins", {24'h0, rd}, 32'h3C);

        // R7: toggle while outputs, direction unchanged
        bus_write(2'd0, 8'h0F);
        bus_read(2'd2, rd); check("R7 toggle val", {24'h0, rd}, 32'h33);
        bus_read(2'd1, rd); check("R7 dir kept", {24'h0, rd}, 32'hFF);
        check("R3 out after toggle", {24'h0, pad_out}, 32'h33);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule